// File: doc/BRIEF.md
# SMBus Transfer Length and Packet Error Check Controller

This block sits next to an I2C/SMBus byte shifter and manages the length of a transfer. Software loads a byte count, a reload option, a packet-error-check option and an acknowledge choice through a register-style write port. The shifter reports each completed byte with a strobe. The block counts the data bytes down and keeps a running CRC-8 over every byte on the bus. When checking is enabled and no reload is pending, it treats the last counted byte as the packet error check byte. In transmit mode it substitutes the computed CRC for that byte. In receive mode it compares the received byte against the CRC and answers a mismatch with a NACK and a sticky error flag.

In reload mode a count that runs out holds the clock low. It stays low until software writes a fresh count, so software can acknowledge bytes one at a time. The final reload clears the reload option, and the last byte counted then becomes the check byte. Data requests to software are raised only for bytes that software must supply. With checking enabled, a count of N therefore produces N-1 requests.

Top module: `smb_len_ctrl`

## Requirements
- R1: After synchronous active-low reset, count_o, crc_o, tx_req_o, stretch_o, nack_o, pec_err_o and pec_last_o are all 0.
- R2: A cfg_we_i write loads cfg_nbytes_i into count_o on the next cycle. Each byte_done_i with byte_is_addr_i low decrements count_o by one on the next cycle. At zero the count stays at zero and does not wrap.
- R3: A byte_done_i with byte_is_addr_i high leaves count_o unchanged.
- R4: crc_o is a CRC-8 with polynomial 0x07 and initial value 0x00, processed MSB first. It is updated with bus_byte_i on every byte_done_i and returns to 0x00 the cycle after start_i. A message followed by its own correct CRC leaves crc_o at 0x00.
- R5: pec_last_o is 1 exactly when checking is enabled, reload is clear and count_o is 1. While pec_last_o and dir_tx_i are both 1, tx_byte_o equals crc_o; otherwise tx_byte_o equals tx_data_i.
- R6: tx_req_o pulses for one cycle after a write or a data byte when dir_tx_i is 1, the new count is nonzero and the new state is not the check byte. With checking enabled, NBYTES=N therefore yields N-1 pulses; with checking disabled it yields N.
- R7: With reload set and count_o at 0, stretch_o is 1 and stays 1 until a cfg_we_i write; it falls on the cycle after the write.
- R8: On a receive data byte (dir_tx_i=0), nack_o is registered as the software choice OR a check-byte mismatch (1 = NACK). nack_o holds its value at all other times.
- R9: A receive check byte that differs from crc_o sets pec_err_o. The flag stays set until a pec_clr_i strobe clears it on the next cycle.
- R10: In transmit mode a completed byte changes neither nack_o nor pec_err_o, even when it differs from crc_o in the check-byte position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | START or repeated START seen on the bus |
| byte_done_i | input | 1 | Shifter finished eight bits of a byte |
| byte_is_addr_i | input | 1 | Completed byte is the address byte |
| dir_tx_i | input | 1 | 1 = block transmits data, 0 = receives |
| bus_byte_i | input | 8 | Byte that was just on the bus |
| cfg_we_i | input | 1 | Write strobe for the programming fields |
| cfg_nbytes_i | input | CNT_W | Byte count to load |
| cfg_reload_i | input | 1 | Reload mode: stretch when the count runs out |
| cfg_pec_i | input | 1 | Last counted byte is the check byte |
| cfg_nack_i | input | 1 | Software acknowledge choice (1 = NACK) |
| pec_clr_i | input | 1 | Write-one-to-clear for the check error flag |
| tx_data_i | input | 8 | Next data byte from software |
| tx_byte_o | output | 8 | Byte the shifter should send next |
| tx_req_o | output | 1 | One-cycle request for the next data byte |
| count_o | output | CNT_W | Bytes remaining |
| pec_last_o | output | 1 | Next byte is the check byte |
| stretch_o | output | 1 | Hold the clock low, waiting for a reload |
| nack_o | output | 1 | Registered acknowledge decision (1 = NACK) |
| pec_err_o | output | 1 | Sticky check-byte mismatch flag |
| crc_o | output | 8 | Running CRC-8 |

## Verification
The count and CRC paths are run with a plain three-byte count with checking in both directions. This separates correct check-byte substitution in transmit from comparison in receive. A good and a corrupted received check byte show that the NACK and the error flag come only from a mismatch. A reload sequence of single-byte counts confirms that stretching, rather than the check byte, happens while reload is set. A transmit run without checking separates N from N-1 data requests. An extra byte after zero, a corrupt transmitted byte and a repeated START cover the boundary rules.

// File: rtl/smb_len_pkg.sv
package smb_len_pkg;

   // one CRC step over a whole byte, bit by bit from the MSB
   function automatic logic [7:0] crc_byte(input logic [7:0] crc_in,
                                           input logic [7:0] data,
                                           input logic [7:0] poly);
      logic [7:0] c;
      logic       fb;
      c = crc_in;
      for (int i = 7; i >= 0; i--) begin
         fb = c[7] ^ data[i];
         c  = {c[6:0], 1'b0} ^ (fb ? poly : 8'h00);
      end
      return c;
   endfunction

endpackage

// File: rtl/smb_len_crc.sv
module smb_len_crc
   import smb_len_pkg::*;
#(
   parameter logic [7:0] POLY        = 8'h07,
   parameter logic [7:0] CRC_INIT    = 8'h00,
   parameter bit         PEC_SUPPORT = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       byte_done,
   input  logic [7:0] data,
   output logic [7:0] crc_q
);

   generate
      if (PEC_SUPPORT) begin : g_crc
         logic [7:0] crc_r;
         always_ff @(posedge clk) begin
            if (!rst_n)         crc_r <= CRC_INIT;
            else if (start)     crc_r <= CRC_INIT;
            else if (byte_done) crc_r <= crc_byte(crc_r, data, POLY);
         end
         assign crc_q = crc_r;

         p_start_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
            start |=> crc_q == CRC_INIT);
         p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!start && !byte_done) |=> $stable(crc_q));
      end else begin : g_nocrc
         assign crc_q = CRC_INIT;
      end
   endgenerate

endmodule

// File: rtl/smb_len_count.sv
module smb_len_count #(
   parameter int CNT_W       = 8,
   parameter bit PEC_SUPPORT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [CNT_W-1:0] cfg_nbytes,
   input  logic             cfg_reload,
   input  logic             cfg_pec,
   input  logic             data_byte,
   input  logic             dir_tx,
   output logic [CNT_W-1:0] cnt_q,
   output logic             pec_phase,
   output logic             stretch,
   output logic             tx_req_q
);

   localparam logic [CNT_W-1:0] ZERO = '0;
   localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

   logic             reload_q, pec_q;
   logic [CNT_W-1:0] cnt_d;
   logic             reload_d, pec_d, req_d;

   always_comb begin
      cnt_d    = cnt_q;
      reload_d = reload_q;
      pec_d    = pec_q;
      if (cfg_we) begin
         cnt_d    = cfg_nbytes;
         reload_d = cfg_reload;
         pec_d    = cfg_pec & PEC_SUPPORT;
      end else if (data_byte && cnt_q != ZERO) begin
         cnt_d = cnt_q - ONE;
      end
      req_d = dir_tx && (cfg_we || data_byte) && cnt_d != ZERO
              && !(pec_d && !reload_d && cnt_d == ONE);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q    <= ZERO;
         reload_q <= 1'b0;
         pec_q    <= 1'b0;
         tx_req_q <= 1'b0;
      end else begin
         cnt_q    <= cnt_d;
         reload_q <= reload_d;
         pec_q    <= pec_d;
         tx_req_q <= req_d;
      end
   end

   assign pec_phase = pec_q && !reload_q && cnt_q == ONE;
   assign stretch   = reload_q && cnt_q == ZERO;

   p_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (data_byte && !cfg_we && cnt_q != ZERO) |=> cnt_q == $past(cnt_q) - ONE);
   p_nowrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (data_byte && !cfg_we && cnt_q == ZERO) |=> cnt_q == ZERO);
   p_stretch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (stretch && !cfg_we) |=> stretch);
   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> cnt_q == $past(cfg_nbytes));

endmodule

// File: rtl/smb_len_ack.sv
module smb_len_ack (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_we,
   input  logic       cfg_nack,
   input  logic       data_byte,
   input  logic       dir_tx,
   input  logic       pec_phase,
   input  logic [7:0] data,
   input  logic [7:0] crc_q,
   input  logic       pec_clr,
   output logic       nack_q,
   output logic       pec_err_q
);

   logic nack_sw_q;
   logic rx_byte, mismatch;

   assign rx_byte  = data_byte && !dir_tx;
   assign mismatch = rx_byte && pec_phase && (data != crc_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         nack_sw_q <= 1'b0;
         nack_q    <= 1'b0;
         pec_err_q <= 1'b0;
      end else begin
         if (cfg_we)  nack_sw_q <= cfg_nack;
         if (rx_byte) nack_q    <= nack_sw_q | mismatch;
         if (mismatch)     pec_err_q <= 1'b1;
         else if (pec_clr) pec_err_q <= 1'b0;
      end
   end

   p_nack_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_byte |=> $stable(nack_q));
   p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pec_err_q && !pec_clr) |=> pec_err_q);
   p_tx_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (data_byte && dir_tx) |=> ($stable(nack_q) && ($stable(pec_err_q) || !pec_err_q)));

endmodule

// File: rtl/smb_len_ctrl.sv
module smb_len_ctrl #(
   parameter int         CNT_W       = 8,
   parameter logic [7:0] POLY        = 8'h07,
   parameter logic [7:0] CRC_INIT    = 8'h00,
   parameter bit         PEC_SUPPORT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             byte_done_i,
   input  logic             byte_is_addr_i,
   input  logic             dir_tx_i,
   input  logic [7:0]       bus_byte_i,
   input  logic             cfg_we_i,
   input  logic [CNT_W-1:0] cfg_nbytes_i,
   input  logic             cfg_reload_i,
   input  logic             cfg_pec_i,
   input  logic             cfg_nack_i,
   input  logic             pec_clr_i,
   input  logic [7:0]       tx_data_i,
   output logic [7:0]       tx_byte_o,
   output logic             tx_req_o,
   output logic [CNT_W-1:0] count_o,
   output logic             pec_last_o,
   output logic             stretch_o,
   output logic             nack_o,
   output logic             pec_err_o,
   output logic [7:0]       crc_o
);

   generate
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_width
         $error("smb_len_ctrl: CNT_W must lie in 2..16");
      end
      if (POLY[0] != 1'b1) begin : g_bad_poly
         $error("smb_len_ctrl: POLY must have its constant term set");
      end
   endgenerate

   logic data_byte;
   assign data_byte = byte_done_i && !byte_is_addr_i;

   smb_len_crc #(.POLY(POLY), .CRC_INIT(CRC_INIT), .PEC_SUPPORT(PEC_SUPPORT)) u_crc (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start_i),
      .byte_done (byte_done_i),
      .data      (bus_byte_i),
      .crc_q     (crc_o)
   );

   smb_len_count #(.CNT_W(CNT_W), .PEC_SUPPORT(PEC_SUPPORT)) u_count (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we_i),
      .cfg_nbytes (cfg_nbytes_i),
      .cfg_reload (cfg_reload_i),
      .cfg_pec    (cfg_pec_i),
      .data_byte  (data_byte),
      .dir_tx     (dir_tx_i),
      .cnt_q      (count_o),
      .pec_phase  (pec_last_o),
      .stretch    (stretch_o),
      .tx_req_q   (tx_req_o)
   );

   smb_len_ack u_ack (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we_i),
      .cfg_nack  (cfg_nack_i),
      .data_byte (data_byte),
      .dir_tx    (dir_tx_i),
      .pec_phase (pec_last_o),
      .data      (bus_byte_i),
      .crc_q     (crc_o),
      .pec_clr   (pec_clr_i),
      .nack_q    (nack_o),
      .pec_err_q (pec_err_o)
   );

   assign tx_byte_o = (pec_last_o && dir_tx_i) ? crc_o : tx_data_i;

   p_req_not_pec_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req_o |-> !pec_last_o);
   p_addr_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done_i && byte_is_addr_i && !cfg_we_i) |=> $stable(count_o));

endmodule

// File: tb/smb_len_ctrl_test.sv
`timescale 1ns/100ps
module smb_len_ctrl_test;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic       start = 0, bd = 0, addr = 0, tx = 0, we = 0, rl = 0, pe = 0, nk = 0, clr = 0;
   logic [7:0] bb = 0, nb = 0, txd = 0;
   logic [7:0] tx_byte, count, crc;
   logic       tx_req, pec_last, stretch, nack, pec_err;

   smb_len_ctrl uut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .byte_done_i(bd),
      .byte_is_addr_i(addr), .dir_tx_i(tx), .bus_byte_i(bb),
      .cfg_we_i(we), .cfg_nbytes_i(nb), .cfg_reload_i(rl), .cfg_pec_i(pe),
      .cfg_nack_i(nk), .pec_clr_i(clr), .tx_data_i(txd),
      .tx_byte_o(tx_byte), .tx_req_o(tx_req), .count_o(count),
      .pec_last_o(pec_last), .stretch_o(stretch), .nack_o(nack),
      .pec_err_o(pec_err), .crc_o(crc)
   );

   int compared = 0, mismatched = 0, req_seen = 0;
   bit finished = 0;

   function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] b);
      logic [7:0] r;
      r = c ^ b;
      repeat (8) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
      return r;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference state
   int  m_cnt = 0;
   bit  m_rel = 0, m_pec = 0, m_nsw = 0, m_nack = 0, m_err = 0, m_req = 0;
   logic [7:0] m_crc = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_rel = 0; m_pec = 0; m_nsw = 0;
         m_nack = 0; m_err = 0; m_req = 0; m_crc = 0;
      end else begin
         automatic bit pl = m_pec && !m_rel && m_cnt == 1;
         automatic logic [7:0] old = m_crc;
         automatic bit mism = 0;
         automatic bit nsw_old = m_nsw;
         if (start) m_crc = 0;
         else if (bd) m_crc = ref_crc(m_crc, bb);
         if (bd && !addr && !tx) begin
            mism = pl && (bb != old);
            m_nack = nsw_old | mism;
         end
         if (mism) m_err = 1;
         else if (clr) m_err = 0;
         m_req = 0;
         if (we) begin
            m_cnt = nb; m_rel = rl; m_pec = pe; m_nsw = nk;
            m_req = tx && m_cnt != 0 && !(m_pec && !m_rel && m_cnt == 1);
         end else if (bd && !addr) begin
            if (m_cnt != 0) m_cnt = m_cnt - 1;
            m_req = tx && m_cnt != 0 && !(m_pec && !m_rel && m_cnt == 1);
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         automatic bit pl = m_pec && !m_rel && m_cnt == 1;
         chk("R2 count", count, m_cnt);
         chk("R4 crc", crc, m_crc);
         chk("R5 pec_last", pec_last, pl);
         chk("R5 tx_byte", tx_byte, (pl && tx) ? m_crc : txd);
         chk("R6 tx_req", tx_req, m_req);
         chk("R7 stretch", stretch, m_rel && m_cnt == 0);
         chk("R8 nack", nack, m_nack);
         chk("R9 pec_err", pec_err, m_err);
         if (tx_req) req_seen++;
      end
   end

   task automatic tick; @(posedge clk); #1; endtask
   task automatic do_start; start = 1; tick; start = 0; endtask
   task automatic do_byte(input logic a, input logic [7:0] b);
      bd = 1; addr = a; bb = b; tick; bd = 0; addr = 0;
   endtask
   task automatic do_cfg(input logic [7:0] n, input logic r, input logic p, input logic k);
      we = 1; nb = n; rl = r; pe = p; nk = k; tick; we = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         mismatched++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      logic [7:0] e;
      logic       nk_before;
      repeat (3) tick;
      // R1 reset state
      chk("R1 count", count, 0);  chk("R1 crc", crc, 0);
      chk("R1 tx_req", tx_req, 0); chk("R1 stretch", stretch, 0);
      chk("R1 nack", nack, 0);    chk("R1 pec_err", pec_err, 0);
      chk("R1 pec_last", pec_last, 0);
      rst_n = 1; tick;

      // transmit, two data bytes plus check byte
      tx = 1; do_start; req_seen = 0;
      do_cfg(3, 0, 1, 0);
      do_byte(1, 8'hA6);
      chk("R3 count after address", count, 3);
      e = ref_crc(8'h00, 8'hA6);
      txd = 8'h12; do_byte(0, txd); e = ref_crc(e, 8'h12);
      txd = 8'h34; do_byte(0, txd); e = ref_crc(e, 8'h34);
      chk("R5 pec_last at last byte", pec_last, 1);
      chk("R5 tx_byte is crc", tx_byte, e);
      do_byte(0, tx_byte); tick;
      chk("R4 crc after own check byte", crc, 0);
      chk("R6 requests with check", req_seen, 2);

      // receive, good check byte
      tx = 0; do_start; do_cfg(3, 0, 1, 0);
      do_byte(1, 8'hA7); e = ref_crc(8'h00, 8'hA7);
      do_byte(0, 8'h55); e = ref_crc(e, 8'h55);
      do_byte(0, 8'hAA); e = ref_crc(e, 8'hAA);
      do_byte(0, e);
      chk("R8 ack on good check", nack, 0);
      chk("R9 no error on good check", pec_err, 0);

      // receive, corrupted check byte
      do_start; do_cfg(3, 0, 1, 0);
      do_byte(1, 8'hA7); e = ref_crc(8'h00, 8'hA7);
      do_byte(0, 8'h01); e = ref_crc(e, 8'h01);
      do_byte(0, 8'h02); e = ref_crc(e, 8'h02);
      do_byte(0, e ^ 8'h01);
      chk("R8 nack on bad check", nack, 1);
      chk("R9 error on bad check", pec_err, 1);
      repeat (2) tick;
      chk("R9 error sticky", pec_err, 1);
      clr = 1; tick; clr = 0;
      chk("R9 error cleared", pec_err, 0);

      // reload, one byte per count
      do_start; do_cfg(1, 1, 1, 0);
      do_byte(1, 8'hA7); e = ref_crc(8'h00, 8'hA7);
      do_byte(0, 8'h3C); e = ref_crc(e, 8'h3C);
      chk("R7 stretch after byte", stretch, 1);
      chk("R5 no check byte while reloading", pec_last, 0);
      repeat (3) tick;
      chk("R7 stretch holds", stretch, 1);
      do_cfg(1, 1, 1, 0);
      chk("R7 stretch released", stretch, 0);
      do_byte(0, 8'hC3); e = ref_crc(e, 8'hC3);
      chk("R7 stretch again", stretch, 1);
      do_cfg(1, 0, 1, 0);
      chk("R5 last reload gives check byte", pec_last, 1);
      do_byte(0, e);
      chk("R8 ack after reload check", nack, 0);
      chk("R7 no stretch at end", stretch, 0);

      // software NACK choice and no wrap at zero
      do_start; do_cfg(2, 0, 0, 1);
      do_byte(1, 8'hA7);
      do_byte(0, 8'h11);
      chk("R8 software nack", nack, 1);
      do_byte(0, 8'h22);
      do_byte(0, 8'h44);
      chk("R2 no wrap at zero", count, 0);

      // transmit without check: N requests
      tx = 1; do_start; req_seen = 0;
      do_cfg(4, 0, 0, 0);
      for (int i = 0; i < 4; i++) do_byte(0, 8'h70 + 8'(i));
      tick;
      chk("R6 requests without check", req_seen, 4);

      // transmit corrupt check byte has no receive effect
      do_start; do_cfg(1, 0, 1, 0);
      nk_before = nack;
      do_byte(0, 8'h5A);
      chk("R10 error unchanged in transmit", pec_err, 0);
      chk("R10 nack unchanged in transmit", nack, nk_before);
      chk("R4 crc nonzero before start", crc != 0, 1);
      do_start;
      chk("R4 crc cleared by start", crc, 0);

      tick;
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule